// File: doc/BRIEF.md
# Transmit MAC Counter Interrupt Unit

This unit sits beside a transmit MAC and counts what leaves the port. Each transmitted frame increments a frame counter and adds its length to a byte counter. Both counters stop at all-ones rather than wrapping. A counter that reaches that value raises its own expiry bit in a status word. Underrun and transfer-error strobes from the transmit path set further status bits. Software reads the status word through a small register port, and the read clears it. A mask word chooses which status bits drive the single interrupt line.

Frame reports arrive on a valid/ready stream carrying the byte length. The unit never applies back-pressure: `tx_frm_ready` is held high, so every cycle with `tx_frm_valid` high counts as exactly one frame. The underrun and transfer-error inputs are plain one-cycle strobes. Register reads return data combinationally for the address presented. A read of the status address clears the word at the following clock edge. A write stores its data at that edge.

Top module: `tx_mac_cnt_irq`

## Requirements
- R1: After reset both counters read 0, the status word reads 0, the mask reads 0x1 and `irq` is low.
- R2: A cycle with `tx_frm_valid` high increments the frame counter (address 2) by one and adds `tx_frm_len` to the byte counter (address 3).
- R3: Status bits are sticky and are set by events: bit 0 by a transmitted frame, bit 1 by `tx_underrun`, bit 4 by `tx_xfer_err`. All other bits not named in R6 or R7 read 0.
- R4: A read of address 0 returns the status word and clears it at that clock edge. An event in the same cycle as the read leaves its bit set afterwards.
- R5: `irq` is high exactly when some status bit is set whose mask bit (address 1, read/write) is 0.
- R6: The frame counter holds at all-ones once reached. Status bit 11 is set only in the cycle the counter first reaches all-ones.
- R7: The byte counter clamps at all-ones when an addition would overflow. Status bit 10 is set only when the counter first reaches all-ones.
- R8: Software writes to address 2 or 3 load that counter. A write takes precedence over a frame counted in the same cycle, and it never sets an expiry bit.
- R9: `tx_frm_ready` is always high, so no frame report is stalled or lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_frm_valid | input | 1 | One transmitted frame is reported this cycle |
| tx_frm_ready | output | 1 | Always 1; the unit accepts every report |
| tx_frm_len | input | LEN_W | Byte length of the reported frame |
| tx_underrun | input | 1 | Transmit underrun strobe |
| tx_xfer_err | input | 1 | Transmit transfer-error strobe |
| reg_addr | input | 2 | 0 status, 1 mask, 2 frame counter, 3 byte counter |
| reg_wr | input | 1 | Write strobe (addresses 1 to 3) |
| reg_rd | input | 1 | Read strobe; clears status when the address is 0 |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The bench builds the unit with its defaults: 32-bit counters, 16-bit frame lengths and a reset mask of 0x1. With full-width counters, saturation is reached by preloading a counter through the register port to a value just below all-ones. A single frame then drives it to all-ones or past it. This covers the first-reach expiry pulse, the clamp on a large byte addition, and the silence of the expiry bit once a counter is already saturated. Coincident read-and-event and write-and-frame cycles check the two precedence rules.

// File: rtl/tx_mac_irq_pkg.sv
package tx_mac_irq_pkg;
  localparam int BIT_FRM  = 0;
  localparam int BIT_UNDR = 1;
  localparam int BIT_XERR = 4;
  localparam int BIT_BEXP = 10;
  localparam int BIT_FEXP = 11;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_FCNT   = 2'd2,
    ADDR_BCNT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tx_sat_counter.sv
module tx_sat_counter #(
  parameter int CNT_W = 32,
  parameter int ADD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             add_en,
  input  logic [ADD_W-1:0] add_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] next_sat;

  always_comb begin
    sum      = {1'b0, count} + {{(CNT_W + 1 - ADD_W){1'b0}}, add_val};
    next_sat = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
    expire   = add_en && !wr_en && (count != MAXV) && (next_sat == MAXV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (wr_en)  count <= wr_data;
    else if (add_en) count <= next_sat;
  end

  // R6 R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV && !wr_en) |=> (count == MAXV));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !wr_en) |=> (count >= $past(count)));

  // R8
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));
endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status #(
  parameter int          W        = 32,
  parameter logic [31:0] MASK_RST = 32'h1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd_clr,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] status_d;

  always_comb status_d = (rd_clr ? '0 : status) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= W'(MASK_RST);
    end else begin
      status <= status_d;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  assign irq = |(status & ~mask);

  // R4
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (status == '0));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/tx_mac_cnt_irq.sv
module tx_mac_cnt_irq #(
  parameter int          CNT_W    = 32,
  parameter int          LEN_W    = 16,
  parameter logic [31:0] MASK_RST = 32'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_frm_valid,
  output logic             tx_frm_ready,
  input  logic [LEN_W-1:0] tx_frm_len,
  input  logic             tx_underrun,
  input  logic             tx_xfer_err,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  import tx_mac_irq_pkg::*;

  logic             frm_acc;
  logic             fcnt_wr, bcnt_wr, mask_wr, stat_rd;
  logic [CNT_W-1:0] fcnt, bcnt, status, mask, set_vec;
  logic             fexp, bexp;

  assign tx_frm_ready = 1'b1;
  assign frm_acc      = tx_frm_valid && tx_frm_ready;

  assign fcnt_wr = reg_wr && (reg_addr == ADDR_FCNT);
  assign bcnt_wr = reg_wr && (reg_addr == ADDR_BCNT);
  assign mask_wr = reg_wr && (reg_addr == ADDR_MASK);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STATUS);

  tx_sat_counter #(.CNT_W(CNT_W), .ADD_W(1)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .wr_en(fcnt_wr), .wr_data(reg_wdata),
    .add_en(frm_acc), .add_val(1'b1), .count(fcnt), .expire(fexp)
  );

  tx_sat_counter #(.CNT_W(CNT_W), .ADD_W(LEN_W)) u_bcnt (
    .clk(clk), .rst_n(rst_n), .wr_en(bcnt_wr), .wr_data(reg_wdata),
    .add_en(frm_acc), .add_val(tx_frm_len), .count(bcnt), .expire(bexp)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_FRM]  = frm_acc;
    set_vec[BIT_UNDR] = tx_underrun;
    set_vec[BIT_XERR] = tx_xfer_err;
    set_vec[BIT_BEXP] = bexp;
    set_vec[BIT_FEXP] = fexp;
  end

  tx_irq_status #(.W(CNT_W), .MASK_RST(MASK_RST)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(stat_rd),
    .mask_wr(mask_wr), .mask_wdata(reg_wdata),
    .status(status), .mask(mask), .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_STATUS: reg_rdata = status;
      ADDR_MASK:   reg_rdata = mask;
      ADDR_FCNT:   reg_rdata = fcnt;
      default:     reg_rdata = bcnt;
    endcase
  end

  // R2
  frm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_acc && !fcnt_wr && fcnt != '1) |=> (fcnt == $past(fcnt) + 1'b1));

  // R9
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frm_valid |-> tx_frm_ready);
endmodule

// File: tb/tx_mac_cnt_irq_tb.sv
module tx_mac_cnt_irq_tb;
  localparam int CNT_W = 32;
  localparam int LEN_W = 16;
  localparam int NV    = 6;

  // {valid, len, underrun, xfer_err, expected status}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 16'd64,   1'b0, 1'b0, 32'h0000_0001},
    {1'b0, 16'd0,    1'b1, 1'b0, 32'h0000_0002},
    {1'b0, 16'd0,    1'b0, 1'b1, 32'h0000_0010},
    {1'b1, 16'd1500, 1'b1, 1'b1, 32'h0000_0013},
    {1'b1, 16'd0,    1'b0, 1'b0, 32'h0000_0001},
    {1'b0, 16'd0,    1'b0, 1'b0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_frm_valid = 1'b0;
  logic tx_frm_ready;
  logic [LEN_W-1:0] tx_frm_len = '0;
  logic tx_underrun = 1'b0;
  logic tx_xfer_err = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  longint fmod = 0;
  longint bmod = 0;

  always #4 clk = ~clk;

  tx_mac_cnt_irq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_frm_valid(tx_frm_valid), .tx_frm_ready(tx_frm_ready),
    .tx_frm_len(tx_frm_len), .tx_underrun(tx_underrun), .tx_xfer_err(tx_xfer_err),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ev(input logic v, input logic [LEN_W-1:0] l, input logic u, input logic x);
    tx_frm_valid = v; tx_frm_len = l; tx_underrun = u; tx_xfer_err = x;
    @(negedge clk);
    tx_frm_valid = 1'b0; tx_underrun = 1'b0; tx_xfer_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R9 ready", {31'd0, tx_frm_ready}, 32'd1);
    rd(2'd1, d); chk("R1 mask", d, 32'h1);
    rd(2'd2, d); chk("R1 fcnt", d, 32'd0);
    rd(2'd3, d); chk("R1 bcnt", d, 32'd0);
    rd(2'd0, d); chk("R1 status", d, 32'd0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [31:0] es;
      es = VEC[i][31:0];
      ev(VEC[i][50], VEC[i][49:34], VEC[i][33], VEC[i][32]);
      if (VEC[i][50]) begin fmod++; bmod += VEC[i][49:34]; end
      chk("R5 irq vec", {31'd0, irq}, {31'd0, |(es & ~32'h1)});
      rd(2'd0, d); chk("R3 status vec", d, es);
      rd(2'd0, d); chk("R4 cleared", d, 32'd0);
      rd(2'd2, d); chk("R2 fcnt", d, fmod[31:0]);
      rd(2'd3, d); chk("R2 bcnt", d, bmod[31:0]);
    end

    // R5 unmask frame bit
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R5 mask rw", d, 32'h0);
    ev(1'b1, 16'd10, 1'b0, 1'b0);
    chk("R5 irq unmasked", {31'd0, irq}, 32'd1);
    // R4 read coinciding with new event
    tx_xfer_err = 1'b1;
    rd(2'd0, d);
    tx_xfer_err = 1'b0;
    chk("R4 read value", d, 32'h1);
    rd(2'd0, d); chk("R4 coincident kept", d, 32'h10);
    chk("R5 irq low", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF);
    ev(1'b0, 16'd0, 1'b1, 1'b0);
    chk("R5 irq all masked", {31'd0, irq}, 32'd0);
    rd(2'd0, d); chk("R3 masked still sticky", d, 32'h2);

    // R6 frame counter saturation
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'd0);
    rd(2'd0, d); chk("R8 write no expiry", d, 32'h0);
    ev(1'b1, 16'd4, 1'b0, 1'b0);
    rd(2'd2, d); chk("R6 fcnt max", d, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R6 fexp bit", d, 32'h801);
    ev(1'b1, 16'd4, 1'b0, 1'b0);
    rd(2'd2, d); chk("R6 fcnt hold", d, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R6 no second fexp", d, 32'h1);

    // R7 byte counter clamp
    wr(2'd2, 32'd0);
    wr(2'd3, 32'hFFFF_FF00);
    ev(1'b1, 16'h0200, 1'b0, 1'b0);
    rd(2'd3, d); chk("R7 bcnt clamp", d, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R7 bexp bit", d, 32'h401);
    ev(1'b1, 16'h0010, 1'b0, 1'b0);
    rd(2'd3, d); chk("R7 bcnt hold", d, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R7 no second bexp", d, 32'h1);

    // R8 write beats concurrent frame
    wr(2'd3, 32'd100);
    wr(2'd2, 32'd7);
    tx_frm_valid = 1'b1; tx_frm_len = 16'd50;
    wr(2'd2, 32'd5);
    tx_frm_valid = 1'b0;
    rd(2'd2, d); chk("R8 fcnt write wins", d, 32'd5);
    rd(2'd3, d); chk("R8 bcnt still adds", d, 32'd150);
    rd(2'd0, d); chk("R8 frame bit set", d, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule